// File: doc/BRIEF.md
# Hands-Free Door Unlock Controller

This block sequences a hands-free car door unlock. While the car is idle, a long inactivity countdown runs. If nobody approaches before it expires, the controller drops into a sleep state. In that state it ignores proximity strobes, and it wakes only after two handle-button presses that fall close enough together. From the awake idle state, a hand-approach strobe starts an identification attempt. The controller raises a card request and waits a bounded time for the card to return its ID word. If that word equals the locally stored ID, the door unlock level goes high and stays high until a lock command arrives.

Every duration is a parameter counted in clock cycles. The defaults assume a slow always-on clock of 1 kHz: three days of inactivity, a one-second wake window and a 50 ms card response window. A testbench can shrink all three. The handle button is an asynchronous level; it is synchronized inside the block and only its rising edge counts. A failed identification returns the controller to idle and restarts the inactivity countdown, whether the card gave a wrong ID or no answer at all.

Top module: `keyless_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller goes to idle: `sys_active`=1, `card_req`=0, `door_unlock`=0, and the inactivity countdown is reloaded to its full length.
- R2: After exactly SLEEP_CYCLES consecutive idle cycles with no hand-approach strobe, `sys_active` goes to 0 (sleep).
- R3: In sleep, `hand_near` and `rx_id_vld` have no effect: `card_req` and `door_unlock` stay 0 and `sys_active` stays 0.
- R4: `handle_btn` (1 = pressed) passes through a two-stage synchronizer and counts once per rising edge. In sleep, a first press opens a window of WAKE_CYCLES cycles. A second press consumed within that window sets `sys_active`=1 and enters idle. When the second press falls on the last cycle of the window, it still wins over the window's expiry. Seen as the gap between the two press strobes, gaps of 2 to WAKE_CYCLES cycles wake the controller.
- R5: When the window expires without a second press, it is cleared and the controller stays asleep. The next press is then treated as a first press.
- R6: In idle, a `hand_near` strobe stops the countdown and raises `card_req` from the next cycle. If the countdown expires in the same cycle, the strobe takes priority.
- R7: If no `rx_id_vld` arrives during RESP_CYCLES cycles of `card_req`, the request drops, the controller returns to idle and the countdown restarts at full length.
- R8: A `rx_id_vld` whose `rx_id` equals the stored ID, while `card_req` is high, drives `door_unlock`=1 (1 = unlock, 0 = lock) from the next cycle. This holds even in the last cycle of the response window.
- R9: A `rx_id_vld` whose `rx_id` differs from the stored ID in any bit, while `card_req` is high, keeps `door_unlock`=0, drops `card_req`, returns to idle and restarts the countdown.
- R10: `door_unlock` stays 1, and `hand_near` is ignored, until `lock_cmd` is sampled high. The controller then locks, returns to idle and restarts the countdown.
- R11: The 32-bit stored ID is written through `id_wr_en`/`id_wr_data` and applies to IDs received from the next cycle on. Its reset value is 0.
- R12: A `rx_id_vld` received while `card_req` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hand_near | input | 1 | One-cycle hand-approach strobe, synchronous |
| handle_btn | input | 1 | Handle button level, asynchronous, 1 = pressed |
| rx_id | input | ID_W | ID word returned by the card |
| rx_id_vld | input | 1 | One-cycle strobe qualifying `rx_id` |
| id_wr_en | input | 1 | Write strobe for the stored ID |
| id_wr_data | input | ID_W | New stored ID value |
| lock_cmd | input | 1 | Lock request; ends the unlocked state |
| card_req | output | 1 | Card identification request |
| sys_active | output | 1 | 1 = awake, 0 = sleeping |
| door_unlock | output | 1 | 1 = unlock, 0 = lock |

## Verification
Two pairs of functions can coincide in one cycle. A second button press can meet the expiry of the wake window, and a card ID can meet the expiry of the response window. The first pair is provoked by sweeping the gap between two presses from 2 to WAKE_CYCLES+3 cycles; `sys_active` is judged three cycles after the second press, and it must rise exactly when the gap is at most WAKE_CYCLES. The second pair is provoked by delivering a matching ID, and separately a wrong ID, in the final requesting cycle. The bench then checks that the unlock level follows the ID and not the timeout.

// File: rtl/kle_pkg.sv
// Shared types of the hands-free door unlock controller.
// Assumes: nothing beyond a single clock domain for all users.
package kle_pkg;

    // Controller states: awake idle, asleep, waiting on the card, doors open
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_REQ   = 2'd2,
        ST_OPEN  = 2'd3
    } kle_state_t;

endpackage

// File: rtl/kle_down_timer.sv
// Reloadable down-counter used for every window of the controller.
// While 'load' is high the count is held at LIMIT-1; while 'run' is high it
// counts down, and 'done' flags the last cycle of a LIMIT-cycle run.
// Assumes: load and run are never high together; LIMIT >= 1.
module kle_down_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count register: reload on reset or load, otherwise step down while running
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt <= TOP;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - W'(1);
        end
    end

    // Last cycle of the window
    assign done = run && (cnt == '0);

endmodule

// File: rtl/kle_btn_edge.sv
// Synchronizes the asynchronous handle button and emits a one-cycle strobe
// per rising edge, so a held button counts as a single press.
// Assumes: a press lasts at least one clock period; no debounce is needed.
module kle_btn_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_async,
    output logic press
);
    logic [STAGES:0] sh;

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], btn_async};
        end
    end

    // Rising edge of the synchronized level
    assign press = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/kle_id_match.sv
// Holds the enrolled card ID and compares it with a received ID word.
// Assumes: a write becomes visible to the comparator in the following cycle.
module kle_id_match #(
    parameter int unsigned ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_data,
    input  logic [ID_W-1:0] cand,
    output logic            equal
);
    logic [ID_W-1:0] stored;

    // Stored ID register with its write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (wr_en) begin
            stored <= wr_data;
        end
    end

    // Full-width equality
    assign equal = (stored == cand);

endmodule

// File: rtl/keyless_entry_ctrl.sv
// Hands-free door unlock controller: inactivity sleep, two-press wake,
// and a card ID request/compare handshake that drives the unlock level.
// Assumes: hand_near, rx_id_vld and lock_cmd are synchronous to clk;
// handle_btn may be asynchronous. All durations are counted in clk cycles.
module keyless_entry_ctrl
    import kle_pkg::*;
#(
    parameter int unsigned ID_W         = 32,
    parameter int unsigned SLEEP_CYCLES = 259_200_000,
    parameter int unsigned WAKE_CYCLES  = 1_000,
    parameter int unsigned RESP_CYCLES  = 50,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hand_near,
    input  logic            handle_btn,
    input  logic [ID_W-1:0] rx_id,
    input  logic            rx_id_vld,
    input  logic            id_wr_en,
    input  logic [ID_W-1:0] id_wr_data,
    input  logic            lock_cmd,
    output logic            card_req,
    output logic            sys_active,
    output logic            door_unlock
);
    kle_state_t state;
    logic       armed;
    logic       press;
    logic       id_equal;
    logic       sleep_done;
    logic       win_done;
    logic       resp_done;
    logic       in_idle;
    logic       win_run;
    logic       in_req;

    assign in_idle = (state == ST_IDLE);
    assign in_req  = (state == ST_REQ);
    assign win_run = (state == ST_SLEEP) && armed;

    kle_btn_edge #(.STAGES(SYNC_STAGES)) i_btn (
        .clk       (clk),
        .rst_n     (rst_n),
        .btn_async (handle_btn),
        .press     (press)
    );

    kle_id_match #(.ID_W(ID_W)) i_id (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (id_wr_en),
        .wr_data (id_wr_data),
        .cand    (rx_id),
        .equal   (id_equal)
    );

    kle_down_timer #(.LIMIT(SLEEP_CYCLES)) i_sleep_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!in_idle),
        .run   (in_idle),
        .done  (sleep_done)
    );

    kle_down_timer #(.LIMIT(WAKE_CYCLES)) i_wake_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!win_run),
        .run   (win_run),
        .done  (win_done)
    );

    kle_down_timer #(.LIMIT(RESP_CYCLES)) i_resp_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (!in_req),
        .run   (in_req),
        .done  (resp_done)
    );

    // Main sequencer: state transitions and the wake-window arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            armed <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    armed <= 1'b0;
                    if (hand_near) begin
                        state <= ST_REQ;
                    end else if (sleep_done) begin
                        state <= ST_SLEEP;
                    end
                end
                ST_SLEEP: begin
                    if (press) begin
                        if (armed) begin
                            state <= ST_IDLE;
                            armed <= 1'b0;
                        end else begin
                            armed <= 1'b1;
                        end
                    end else if (win_done) begin
                        armed <= 1'b0;
                    end
                end
                ST_REQ: begin
                    if (rx_id_vld) begin
                        state <= id_equal ? ST_OPEN : ST_IDLE;
                    end else if (resp_done) begin
                        state <= ST_IDLE;
                    end
                end
                ST_OPEN: begin
                    if (lock_cmd) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    armed <= 1'b0;
                end
            endcase
        end
    end

    // Output decode straight from the state register
    assign card_req    = in_req;
    assign sys_active  = (state != ST_SLEEP);
    assign door_unlock = (state == ST_OPEN);

endmodule

// File: rtl/kle_checker.sv
// Port-level properties of the hands-free door unlock controller.
// Assumes: attached to every instance of keyless_entry_ctrl through bind.
module kle_checker (
    input logic clk,
    input logic rst_n,
    input logic hand_near,
    input logic rx_id_vld,
    input logic lock_cmd,
    input logic card_req,
    input logic sys_active,
    input logic door_unlock
);

    // R1: a reset edge leaves the controller awake, locked, not requesting
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (sys_active && !card_req && !door_unlock));

    // R3: while asleep, proximity and ID strobes start nothing
    assert_sleep_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_active && (hand_near || rx_id_vld)) |=> (!card_req && !door_unlock));

    // R4: waking always lands in idle, never straight into a request or unlock
    assert_wake_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_active) |-> (!card_req && !door_unlock));

    // R6: a hand strobe in idle raises the request on the next cycle
    assert_idle_hand_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_active && !card_req && !door_unlock && hand_near) |=> card_req);

    // R7: the end of a request always leaves the controller awake
    assert_req_end_awake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(card_req) |-> sys_active);

    // R8: unlocking only follows an ID strobe during a request
    assert_unlock_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(door_unlock) |-> $past(card_req && rx_id_vld));

    // R10: unlock is held until a lock command
    assert_unlock_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (door_unlock && !lock_cmd) |=> door_unlock);

    // R10: a lock command closes the doors and returns to idle
    assert_lock_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (door_unlock && lock_cmd) |=> (!door_unlock && sys_active && !card_req));

endmodule

bind keyless_entry_ctrl kle_checker i_kle_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hand_near   (hand_near),
    .rx_id_vld   (rx_id_vld),
    .lock_cmd    (lock_cmd),
    .card_req    (card_req),
    .sys_active  (sys_active),
    .door_unlock (door_unlock)
);

// File: tb/test_keyless_entry_ctrl.sv
// Self-checking bench for keyless_entry_ctrl with shortened durations.
module test_keyless_entry_ctrl;

    localparam int unsigned SLP  = 40;
    localparam int unsigned WIN  = 8;
    localparam int unsigned RSP  = 6;
    localparam logic [31:0] KEY  = 32'hC0DE_5A17;
    localparam logic [31:0] KEY2 = 32'h1234_ABCD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hand_near = 1'b0;
    logic        handle_btn = 1'b0;
    logic [31:0] rx_id = '0;
    logic        rx_id_vld = 1'b0;
    logic        id_wr_en = 1'b0;
    logic [31:0] id_wr_data = '0;
    logic        lock_cmd = 1'b0;
    logic        card_req;
    logic        sys_active;
    logic        door_unlock;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    keyless_entry_ctrl #(
        .ID_W(32), .SLEEP_CYCLES(SLP), .WAKE_CYCLES(WIN), .RESP_CYCLES(RSP), .SYNC_STAGES(2)
    ) i_keyless_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .hand_near(hand_near), .handle_btn(handle_btn),
        .rx_id(rx_id), .rx_id_vld(rx_id_vld), .id_wr_en(id_wr_en), .id_wr_data(id_wr_data),
        .lock_cmd(lock_cmd), .card_req(card_req), .sys_active(sys_active),
        .door_unlock(door_unlock)
    );

    // Advance n edges and sample 1 ns after the last one
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Called in the first idle cycle: sleep must come after exactly SLP cycles
    task automatic expect_sleep_in(input string tag);
        tick(SLP - 1);
        chk(sys_active, 1, {tag, " awake just before countdown end"});
        tick(1);
        chk(sys_active, 0, {tag, " asleep at countdown end"});
    endtask

    // Two presses whose strobes are d cycles apart; sample 3 cycles after the second
    task automatic two_presses(input int d);
        handle_btn = 1'b1; tick(1); handle_btn = 1'b0;
        tick(d - 1);
        handle_btn = 1'b1; tick(1); handle_btn = 1'b0;
        tick(2);
    endtask

    task automatic pulse_hand();
        hand_near = 1'b1; tick(1); hand_near = 1'b0;
    endtask

    task automatic send_id(input logic [31:0] v);
        rx_id = v; rx_id_vld = 1'b1; tick(1); rx_id_vld = 1'b0;
    endtask

    task automatic do_lock();
        lock_cmd = 1'b1; tick(1); lock_cmd = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        chk(sys_active, 1, "R1 active after reset");
        chk(card_req, 0, "R1 no request after reset");
        chk(door_unlock, 0, "R1 locked after reset");
        // R11 enrol, then R2 countdown from reset (the write is not activity)
        id_wr_data = KEY; id_wr_en = 1'b1; tick(1); id_wr_en = 1'b0;
        tick(SLP - 2);
        chk(sys_active, 1, "R2 awake before countdown end");
        tick(1);
        chk(sys_active, 0, "R2 asleep after full countdown");

        // R3 / R12: stimuli while asleep do nothing
        pulse_hand();
        send_id(KEY);
        tick(3);
        chk(card_req, 0, "R3 no request while asleep");
        chk(door_unlock, 0, "R3 locked while asleep");
        chk(sys_active, 0, "R3 still asleep");

        // R4 / R5: sweep the gap between the two presses
        for (int d = 2; d <= int'(WIN) + 3; d++) begin
            two_presses(d);
            if (d <= int'(WIN)) begin
                chk(sys_active, 1, $sformatf("R4 wake with gap %0d", d));
                for (int k = 0; k < int'(SLP) + 5 && sys_active; k++) tick(1);
            end else begin
                chk(sys_active, 0, $sformatf("R5 no wake with gap %0d", d));
                tick(WIN + 2);
                chk(sys_active, 0, $sformatf("R5 still asleep after window, gap %0d", d));
            end
        end
        // R5: a press after an expired window counts as a first press
        handle_btn = 1'b1; tick(1); handle_btn = 1'b0;
        tick(WIN + 3);
        handle_btn = 1'b1; tick(1); handle_btn = 1'b0;
        tick(2);
        chk(sys_active, 0, "R5 window cleared, later press is a first press");
        tick(WIN + 2);

        // R6 / R7: request then no answer
        two_presses(2);
        pulse_hand();
        chk(card_req, 1, "R6 request after hand strobe");
        tick(RSP - 1);
        chk(card_req, 1, "R7 request held through response window");
        tick(1);
        chk(card_req, 0, "R7 request dropped on timeout");
        expect_sleep_in("R7");

        // R8 / R10: match, hold, ignore hand, lock
        two_presses(2);
        pulse_hand();
        tick(1);
        send_id(KEY);
        chk(door_unlock, 1, "R8 unlock on matching ID");
        chk(card_req, 0, "R8 request ends on match");
        pulse_hand();
        send_id(KEY2);
        tick(3);
        chk(door_unlock, 1, "R10 unlock held, hand ignored");
        chk(card_req, 0, "R10 no request while unlocked");
        do_lock();
        chk(door_unlock, 0, "R10 locked after lock command");
        chk(sys_active, 1, "R10 idle after lock");
        expect_sleep_in("R10");

        // R8: match in the last requesting cycle beats the timeout
        two_presses(2);
        pulse_hand();
        tick(RSP - 1);
        send_id(KEY);
        chk(door_unlock, 1, "R8 match on last window cycle unlocks");
        do_lock();
        // R9: mismatch in the last requesting cycle stays locked
        pulse_hand();
        tick(RSP - 1);
        send_id(KEY ^ 32'h1);
        chk(door_unlock, 0, "R9 mismatch on last window cycle stays locked");

        // R9: every single-bit corruption is rejected
        for (int b = 0; b < 32; b++) begin
            pulse_hand();
            send_id(KEY ^ (32'h1 << b));
            chk({card_req, door_unlock, sys_active}, 3'b001,
                $sformatf("R9 mismatch bit %0d rejected", b));
        end
        expect_sleep_in("R9");

        // R11: new ID takes over from the next cycle
        two_presses(2);
        id_wr_data = KEY2; id_wr_en = 1'b1; tick(1); id_wr_en = 1'b0;
        pulse_hand();
        send_id(KEY);
        chk(door_unlock, 0, "R11 old ID rejected after rewrite");
        pulse_hand();
        send_id(KEY2);
        chk(door_unlock, 1, "R11 new ID accepted");
        do_lock();

        // R12: ID strobe in idle is ignored
        send_id(KEY2);
        tick(1);
        chk({card_req, door_unlock}, 2'b00, "R12 ID outside request ignored");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule